// File: doc/BRIEF.md
# Programmable Interval Timer with Prescaler

This block is a register-mapped interval timer. A prescaler divides the core clock by a 4-bit divisor to form a counting tick. On every tick a 32-bit counter steps upward. When the count matches the stored period, the block raises an interrupt pulse, drives its timer pin and returns the count to zero. Software programs the period as the desired tick count minus one, clears the count and then picks the run mode. The choices are stopped, a single run, or repeating runs.

The counter is only live when two conditions in the global control word hold: the low-half release bit is set, and the mode field selects the split 32-bit arrangement. Otherwise the counter is pinned at zero. The timer pin can give a short pulse or a square wave that flips on each match. Either form can be inverted.

All access goes through a plain word bus. The address is in bytes and reads are combinational. A write takes effect at the clock edge on which `busWe` is high. Byte offsets: 0x04 clock-speed word, 0x10 count, 0x18 period, 0x20 timer control, 0x24 global control. Every other offset, including the high count and high period words, reads zero and ignores writes.

Top module: `interval_timer`

## Requirements
- R1: After reset every register reads 0, the timer pin is 0 and the interrupt is 0. The divisor sits in bits 19:16 of offset 0x04. Global control at 0x24 keeps bits 3:0 and reads 0 above them. Timer control at 0x20 keeps bits 9, 8, 7:6, 5:4, 3 and 1, reads bit 2 as 0, and reads bit 0 as the current timer pin level.
- R2: The counter is held at 0, reads 0 (writes to it included) and produces no interrupt unless both of these hold: global bit 0 is 1, and global bits 3:2 equal 01. Once both hold, counting starts from 0.
- R3: Ticks come every D core cycles, where D is the divisor value, and a divisor of 0 acts as 1. The prescaler starts from zero when the enable field becomes active.
- R4: A match of count and period on a tick produces a one-cycle interrupt and returns the count to 0. Starting from count 0, the first interrupt is visible (P+1)*D cycles after the enabling write edge.
- R5: Enable field (control bits 7:6) value 10 is continuous mode. In this mode interrupts repeat every (P+1)*D cycles.
- R6: Enable field value 01 is one-shot mode. In this mode exactly one interrupt occurs, after which the enable field reads 00 and the count reads 0.
- R7: Enable field values 00 and 11 stop the counter at the edge of the write. While it is stopped, count and period can be rewritten and read back, and a later enable resumes from the written count.
- R8: In pulse mode (control bit 3 = 0), a match drives the timer pin high for (width field, bits 5:4) + 1 core cycles, starting in the interrupt cycle. Control bit 1 inverts the pin.
- R9: In clock mode (control bit 3 = 1), the timer pin toggles at every match.
- R10: Control bit 8 = 1 selects an external clock source, which is not wired. With this bit set, no ticks occur, the count does not advance and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 6 | Byte address of the register |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| timerPin | output | 1 | Timer output pin |
| irqPulse | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, a 4-bit divisor and a 2-bit pulse width. It keeps the divisor in the range 0 to 4 and the period in the range 0 to 5, which makes a full grid of divisor-by-period cases cheap to run. In that grid, the first and second interrupt times are compared with (P+1)*D arithmetic, including the back-to-back case where period 0 gives an interrupt on every cycle. Short directed runs then cover the single-run, stop-and-rewrite, hold, pin-shape and source-select cases with exact cycle counts.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    EN_OFF  = 2'b00,
    EN_ONCE = 2'b01,
    EN_CONT = 2'b10,
    EN_RSVD = 2'b11
  } enMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hold;   // half in reset or wrong global mode
    logic tick;   // prescaled count tick
    logic cntWr;  // bus write to the count register
  } tmrStrobe_t;

  // byte offsets decoded by the bus
  localparam int OFF_CLK = 'h04;
  localparam int OFF_CNT = 'h10;
  localparam int OFF_PRD = 'h18;
  localparam int OFF_CTL = 'h20;
  localparam int OFF_GLB = 'h24;

  // field positions
  localparam int DIV_LSB   = 16;
  localparam int PW_LSB    = 4;
  localparam int EN_LSB    = 6;
  localparam int TMODE_LSB = 2;
  localparam logic [1:0] TMODE_SPLIT = 2'b01;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 4,
  parameter int PW_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              pinVal,
  input  logic              hitEvent,
  output tmrStrobe_t        strb,
  output logic [CNT_W-1:0]  periodVal,
  output logic              clkMode,
  output logic              invOut,
  output logic [PW_W-1:0]   pulseWidth
);

  logic [DIV_W-1:0] divQ, divCnt, divTop;
  logic [CNT_W-1:0] periodQ;
  enMode_e          enModeQ;
  logic             srcSelQ, inEnQ, clkModeQ, invQ;
  logic [PW_W-1:0]  pwQ;
  logic             relLoQ, relHiQ;
  logic [1:0]       tmodeQ;
  logic             released, running, lastPhase;
  logic             wrClk, wrCnt, wrPrd, wrCtl, wrGlb;

  assign wrClk = busWe && (busAddr == ADDR_W'(OFF_CLK));
  assign wrCnt = busWe && (busAddr == ADDR_W'(OFF_CNT));
  assign wrPrd = busWe && (busAddr == ADDR_W'(OFF_PRD));
  assign wrCtl = busWe && (busAddr == ADDR_W'(OFF_CTL));
  assign wrGlb = busWe && (busAddr == ADDR_W'(OFF_GLB));

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divQ     <= '0;
      periodQ  <= '0;
      enModeQ  <= EN_OFF;
      srcSelQ  <= 1'b0;
      inEnQ    <= 1'b0;
      clkModeQ <= 1'b0;
      invQ     <= 1'b0;
      pwQ      <= '0;
      relLoQ   <= 1'b0;
      relHiQ   <= 1'b0;
      tmodeQ   <= '0;
    end else begin
      if (wrClk) divQ <= busWdata[DIV_LSB +: DIV_W];
      if (wrPrd) periodQ <= busWdata[CNT_W-1:0];
      if (wrCtl) begin
        enModeQ  <= enMode_e'(busWdata[EN_LSB +: 2]);
        srcSelQ  <= busWdata[8];
        inEnQ    <= busWdata[9];
        clkModeQ <= busWdata[3];
        invQ     <= busWdata[1];
        pwQ      <= busWdata[PW_LSB +: PW_W];
      end else if (hitEvent && enModeQ == EN_ONCE) begin
        enModeQ <= EN_OFF;  // single run finished
      end
      if (wrGlb) begin
        relLoQ <= busWdata[0];
        relHiQ <= busWdata[1];
        tmodeQ <= busWdata[TMODE_LSB +: 2];
      end
    end
  end

  assign released = relLoQ && (tmodeQ == TMODE_SPLIT);
  assign running  = released && !srcSelQ &&
                    (enModeQ == EN_ONCE || enModeQ == EN_CONT);

  // prescaler: divisor 0 behaves as 1
  assign divTop    = (divQ == '0) ? '0 : divQ - 1'b1;
  assign lastPhase = (divCnt == divTop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      divCnt <= '0;
    else if (!running || lastPhase)  divCnt <= '0;
    else                             divCnt <= divCnt + 1'b1;
  end

  assign strb.hold  = !released;
  assign strb.tick  = running && lastPhase;
  assign strb.cntWr = wrCnt;

  assign periodVal  = periodQ;
  assign clkMode    = clkModeQ;
  assign invOut     = invQ;
  assign pulseWidth = pwQ;

  // read mux
  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_W'(OFF_CLK): busRdata[DIV_LSB +: DIV_W] = divQ;
      ADDR_W'(OFF_CNT): busRdata[CNT_W-1:0] = cntVal;
      ADDR_W'(OFF_PRD): busRdata[CNT_W-1:0] = periodQ;
      ADDR_W'(OFF_CTL): begin
        busRdata[0]               = pinVal;
        busRdata[1]               = invQ;
        busRdata[3]               = clkModeQ;
        busRdata[PW_LSB +: PW_W]  = pwQ;
        busRdata[EN_LSB +: 2]     = enModeQ;
        busRdata[8]               = srcSelQ;
        busRdata[9]               = inEnQ;
      end
      ADDR_W'(OFF_GLB): begin
        busRdata[0]              = relLoQ;
        busRdata[1]              = relHiQ;
        busRdata[TMODE_LSB +: 2] = tmodeQ;
      end
      default: busRdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] periodVal,
  input  logic             clkMode,
  input  logic             invOut,
  input  logic [PW_W-1:0]  pulseWidth,
  output logic [CNT_W-1:0] cntVal,
  output logic             hitEvent,
  output logic             irqPulse,
  output logic             pinOut
);

  localparam int PC_W = PW_W + 1;

  logic [CNT_W-1:0] cntQ;
  logic [PC_W-1:0]  pulseQ;
  logic             toggleQ, irqQ, rawPin;

  assign hitEvent = strb.tick && (cntQ == periodVal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cntQ <= '0;
    else if (strb.hold)  cntQ <= '0;
    else if (strb.cntWr) cntQ <= wrData;
    else if (hitEvent)   cntQ <= '0;
    else if (strb.tick)  cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqQ    <= 1'b0;
      pulseQ  <= '0;
      toggleQ <= 1'b0;
    end else if (strb.hold) begin
      irqQ    <= 1'b0;
      pulseQ  <= '0;
      toggleQ <= 1'b0;
    end else begin
      irqQ <= hitEvent;
      if (hitEvent)            pulseQ <= PC_W'(pulseWidth) + 1'b1;
      else if (pulseQ != '0)   pulseQ <= pulseQ - 1'b1;
      if (hitEvent)            toggleQ <= !toggleQ;
    end
  end

  assign rawPin   = clkMode ? toggleQ : (pulseQ != '0);
  assign pinOut   = rawPin ^ invOut;
  assign cntVal   = cntQ;
  assign irqPulse = irqQ;

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 4,
  parameter int PW_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              timerPin,
  output logic              irqPulse
);

  tmrStrobe_t       strbW;
  logic [CNT_W-1:0] cntW, periodW;
  logic             hitW, clkModeW, invW, pinW, irqW;
  logic [PW_W-1:0]  pwW;

  tmr_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .PW_W(PW_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .cntVal(cntW), .pinVal(pinW),
    .hitEvent(hitW), .strb(strbW), .periodVal(periodW), .clkMode(clkModeW),
    .invOut(invW), .pulseWidth(pwW)
  );

  tmr_datapath #(.CNT_W(CNT_W), .PW_W(PW_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strbW), .wrData(busWdata[CNT_W-1:0]),
    .periodVal(periodW), .clkMode(clkModeW), .invOut(invW), .pulseWidth(pwW),
    .cntVal(cntW), .hitEvent(hitW), .irqPulse(irqW), .pinOut(pinW)
  );

  assign timerPin = pinW;
  assign irqPulse = irqW;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input tmrStrobe_t       strb,
  input logic [CNT_W-1:0] cntVal,
  input logic             irqPulse,
  input logic             pinOut,
  input logic             clkMode,
  input logic             invOut
);

  p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.hold |=> (cntVal == '0 && !irqPulse));

  p_irq_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> $past(strb.tick));

  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irqPulse && !$past(strb.cntWr)) |-> cntVal == '0);

  p_stopped_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.tick && !strb.hold && !strb.cntWr) |=> $stable(cntVal));

  p_pulse_on_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irqPulse && !clkMode) |-> (pinOut != invOut));

endmodule

bind interval_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strb(strbW), .cntVal(cntW), .irqPulse(irqW),
  .pinOut(pinW), .clkMode(clkModeW), .invOut(invW)
);

// File: tb/sim_interval_timer.sv
module sim_interval_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        timerPin, irqPulse;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .timerPin(timerPin),
    .irqPulse(irqPulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  // the last write is the enabling edge; returns one negedge later
  task automatic setupRun(input int dv, input int per, input logic [31:0] ctl);
    wr(6'h24, 32'h0);
    wr(6'h24, 32'h5);
    wr(6'h04, 32'(dv) << 16);
    wr(6'h20, 32'h0);
    wr(6'h18, 32'(per));
    wr(6'h10, 32'h0);
    wr(6'h20, ctl);
  endtask

  task automatic firstTwo(input int limit, output int t1, output int t2);
    t1 = -1; t2 = -1;
    for (int i = 1; i <= limit && t2 < 0; i++) begin
      @(negedge clk);
      if (irqPulse) begin
        if (t1 < 0) t1 = i; else t2 = i;
      end
    end
  endtask

  task automatic countIrq(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irqPulse) c++;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t1, t2, n;
    logic [31:0] pins [1:13];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(6'h04, v); chk("R1 clk word reset", v, 0);
    rd(6'h10, v); chk("R1 count reset", v, 0);
    rd(6'h18, v); chk("R1 period reset", v, 0);
    rd(6'h20, v); chk("R1 control reset", v, 0);
    rd(6'h24, v); chk("R1 global reset", v, 0);
    chk("R1 pin reset", {31'b0, timerPin}, 0);
    chk("R1 irq reset", {31'b0, irqPulse}, 0);

    // R1 field positions
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); chk("R1 divisor field", v, 32'h000F_0000);
    wr(6'h04, 32'h000A_0000); rd(6'h04, v); chk("R1 divisor value", v, 32'h000A_0000);
    wr(6'h24, 32'hFFFF_FFFF); rd(6'h24, v); chk("R1 global field", v, 32'hF);
    wr(6'h20, 32'h0000_033E); rd(6'h20, v); chk("R1 control field", v, 32'h33B);
    wr(6'h20, 32'h0);
    wr(6'h1C, 32'h1234); rd(6'h1C, v); chk("R1 high period reads 0", v, 0);

    // R3 R4 R5 sweep over divisor and period in continuous mode
    for (int dv = 0; dv <= 4; dv++) begin
      for (int p = 0; p <= 5; p++) begin
        int d;
        d = (dv == 0) ? 1 : dv;
        setupRun(dv, p, 32'h80);
        firstTwo(70, t1, t2);
        chk($sformatf("R4 R3 first irq div=%0d per=%0d", dv, p), 32'(t1), 32'((p + 1) * d));
        chk($sformatf("R5 repeat irq div=%0d per=%0d", dv, p), 32'(t2), 32'(2 * (p + 1) * d));
      end
    end

    // R6 one-shot
    setupRun(2, 3, 32'h40);
    firstTwo(8, t1, t2);
    chk("R6 one-shot first irq", 32'(t1), 8);
    countIrq(30, n);
    chk("R6 one-shot no repeat", 32'(n), 0);
    rd(6'h20, v); chk("R6 enable field cleared", v & 32'hC0, 0);
    rd(6'h10, v); chk("R6 count back to 0", v, 0);

    // R2 hold conditions
    wr(6'h04, 32'h0);
    wr(6'h24, 32'h1);
    wr(6'h18, 32'd5);
    wr(6'h10, 32'd3);
    rd(6'h10, v); chk("R2 count write ignored while held", v, 0);
    wr(6'h20, 32'h80);
    countIrq(20, n); chk("R2 no irq with mode 00", 32'(n), 0);
    rd(6'h10, v); chk("R2 count 0 with mode 00", v, 0);
    wr(6'h24, 32'h4);
    countIrq(20, n); chk("R2 no irq without release", 32'(n), 0);
    rd(6'h10, v); chk("R2 count 0 without release", v, 0);
    wr(6'h24, 32'h5);
    firstTwo(20, t1, t2);
    chk("R2 counting starts from 0 on release", 32'(t1), 6);

    // R7 stop, rewrite, resume
    setupRun(0, 100, 32'h80);
    repeat (10) @(negedge clk);
    wr(6'h20, 32'h0);
    repeat (5) @(negedge clk);
    rd(6'h10, v); chk("R7 count frozen at stop edge", v, 12);
    wr(6'h10, 32'd5);
    wr(6'h18, 32'd7);
    rd(6'h10, v); chk("R7 count rewritten", v, 5);
    rd(6'h18, v); chk("R7 period rewritten", v, 7);
    wr(6'h20, 32'h80);
    firstTwo(40, t1, t2);
    chk("R7 resume from written count", 32'(t1), 3);
    chk("R7 full period after resume", 32'(t2), 11);

    // R7 enable value 11 acts as stopped
    setupRun(0, 2, 32'hC0);
    countIrq(20, n); chk("R7 enable 11 no irq", 32'(n), 0);
    rd(6'h10, v); chk("R7 enable 11 count 0", v, 0);

    // R10 external source selected
    setupRun(0, 2, 32'h180);
    countIrq(20, n); chk("R10 no irq on external source", 32'(n), 0);
    rd(6'h10, v); chk("R10 count does not advance", v, 0);

    // R8 pulse width field 2 -> 3 cycles
    setupRun(0, 9, 32'hA0);
    for (int i = 1; i <= 13; i++) begin
      @(negedge clk);
      pins[i] = {31'b0, timerPin};
      if (i == 11) begin rd(6'h20, v); chk("R8 status mirrors pin", v & 1, 1); end
    end
    chk("R8 pin low before match", pins[9], 0);
    chk("R8 pin high cycle 1", pins[10], 1);
    chk("R8 pin high cycle 3", pins[12], 1);
    chk("R8 pin low after width", pins[13], 0);

    // R8 inverted
    setupRun(0, 9, 32'hA2);
    for (int i = 1; i <= 13; i++) begin
      @(negedge clk);
      pins[i] = {31'b0, timerPin};
    end
    chk("R8 inverted idle level", pins[5], 1);
    chk("R8 inverted pulse level", pins[10], 0);
    chk("R8 inverted after pulse", pins[13], 1);

    // R9 clock mode toggling
    setupRun(0, 4, 32'h88);
    for (int i = 1; i <= 11; i++) begin
      @(negedge clk);
      pins[i] = {31'b0, timerPin};
    end
    chk("R9 low before first match", pins[4], 0);
    chk("R9 toggles high at match", pins[5], 1);
    chk("R9 holds between matches", pins[9], 1);
    chk("R9 toggles low at next match", pins[10], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule